// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash device and decides when a program or erase operation that the host has already sent has finished. Software or a sequencer starts the block only after the final bus write of the command sequence. A start pulse carries the operation kind, the target address and, for a program, the data that was written. The block then reads the device status over a simple request/acknowledge read port. It always reads from the target address with its two lowest bits cleared.

Each status word is judged on two bits. Bit 7 is the completion bit. It is compared with an expected value: bit 7 of the written data for a program, and 1 for an erase. Bit 5 is the device's timing-limit flag. When bit 7 does not yet match and bit 5 is set, the block reads bit 7 one more time, because the operation may have finished just as the flag rose. A match on that read is a success. Otherwise the operation has failed. A budget counter caps the number of status reads for one operation.

On any failure the block writes the device's return-to-read command over a request/acknowledge write port. It reports the failure only after that write has been accepted. The block drives `busy` for the whole operation and gives exactly one result pulse, either `done` or `fail`, for each start it accepts.

Top module: `flash_done_poller`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `fail`, `rd_req` and `wr_req` are all 0.
- R2: A `start` seen while idle raises `busy` and `rd_req` on the next cycle. A `start` seen while `busy` is 1 is ignored: the operation kind, the address and the data that were latched stay unchanged.
- R3: Every status read, for program and for erase alike, uses the target address with bits [1:0] forced to 0. `rd_addr` is held stable while `rd_req` waits for `rd_ack`.
- R4: For a program (`op_erase`=0), the operation succeeds on the first status word whose bit 7 equals bit 7 of `wdata`.
- R5: For an erase (`op_erase`=1), the operation succeeds on the first status word whose bit 7 is 1.
- R6: When bit 7 does not match and bit 5 is 1, exactly one more status read is made, provided the budget allows it. A match on that read gives success. A mismatch gives failure, whatever bit 5 shows.
- R7: When bit 7 does not match and bit 5 is 0, another status read follows.
- R8: At most MAX_POLLS status reads are made per operation. If the read that reaches the limit does not match, the operation fails.
- R9: Every failure is preceded by exactly one write of RST_CMD (default 8'hF0) to the poll address, and `fail` pulses on the cycle after `wr_ack` is accepted. A success issues no write.
- R10: `busy` stays 1 from the cycle after an accepted start until the result. Exactly one one-cycle pulse of `done` or `fail` appears per accepted start, and it appears in the cycle in which `busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| op_erase | input | 1 | 1 = erase operation, 0 = program operation |
| target_addr | input | ADDR_W | Programmed address, or an address inside an erased block |
| wdata | input | DATA_W | Data that was programmed |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_addr | output | ADDR_W | Status read address |
| rd_ack | input | 1 | Read acknowledge; rd_data is valid in the same cycle |
| rd_data | input | DATA_W | Status word returned by the device |
| wr_req | output | 1 | Command write request, held until acknowledged |
| wr_addr | output | ADDR_W | Command write address |
| wr_data | output | DATA_W | Command write data (RST_CMD) |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The bench sweeps both operation kinds and both values of the programmed bit 7. For each, it also sweeps every read index at which bit 7 first matches and every read index at which bit 5 first rises, including indices past the read budget. Cases where the match comes before the flag check the plain completion path. Cases where the flag comes first separate a success on the extra read from a failure on it. Cases where neither arrives in time isolate the budget limit. In every run a second start with a different address and kind is sent while the block is busy, so any read at the wrong address or any change of expected value shows up.

// File: rtl/fp_pkg.sv
package fp_pkg;

  // Poll controller states
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_EVAL   = 3'd2,
    ST_RCHK   = 3'd3,
    ST_RCHK_E = 3'd4,
    ST_RSTWR  = 3'd5
  } fp_state_t;

  // Verdict from one evaluated status word
  typedef enum logic [1:0] {
    VD_MATCH  = 2'd0,
    VD_TOUT   = 2'd1,
    VD_AGAIN  = 2'd2
  } fp_verdict_t;

endpackage

// File: rtl/fp_addr_gen.sv
module fp_addr_gen #(
  parameter int ADDR_W     = 24,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] poll_addr
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_addr <= '0;
    end else if (load) begin
      poll_addr <= base_addr & ALIGN_MASK;
    end
  end
endmodule

// File: rtl/fp_status_eval.sv
module fp_status_eval #(
  parameter int DATA_W   = 16,
  parameter int DONE_BIT = 7,
  parameter int TOUT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              is_erase,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] status_in,
  output fp_pkg::fp_verdict_t verdict
);
  import fp_pkg::*;

  logic expect_q;
  logic done_q;
  logic tout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_q <= 1'b0;
    end else if (load) begin
      expect_q <= is_erase ? 1'b1 : wdata[DONE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      tout_q <= 1'b0;
    end else if (capture) begin
      done_q <= status_in[DONE_BIT];
      tout_q <= status_in[TOUT_BIT];
    end
  end

  always_comb begin
    if (done_q == expect_q) begin
      verdict = VD_MATCH;
    end else if (tout_q) begin
      verdict = VD_TOUT;
    end else begin
      verdict = VD_AGAIN;
    end
  end
endmodule

// File: rtl/fp_poll_budget.sv
module fp_poll_budget #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic spent
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS);

  logic [CW-1:0] used_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      used_q <= '0;
    end else if (bump && used_q != LIMIT) begin
      used_q <= used_q + CW'(1);
    end
  end

  assign spent = (used_q == LIMIT);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int DONE_BIT   = 7,
  parameter int TOUT_BIT   = 5,
  parameter int ALIGN_BITS = 2,
  parameter int MAX_POLLS  = 4096,
  parameter logic [DATA_W-1:0] RST_CMD = DATA_W'('hF0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  import fp_pkg::*;

  fp_state_t   state_q;
  fp_verdict_t verdict;
  logic        accept;
  logic        rd_take;
  logic        spent;
  logic [ADDR_W-1:0] poll_addr;

  assign accept  = start && (state_q == ST_IDLE);
  assign rd_take = rd_req && rd_ack;

  fp_addr_gen #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .base_addr (target_addr),
    .poll_addr (poll_addr)
  );

  fp_status_eval #(
    .DATA_W   (DATA_W),
    .DONE_BIT (DONE_BIT),
    .TOUT_BIT (TOUT_BIT)
  ) u_eval (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .is_erase  (op_erase),
    .wdata     (wdata),
    .capture   (rd_take),
    .status_in (rd_data),
    .verdict   (verdict)
  );

  fp_poll_budget #(
    .MAX_POLLS (MAX_POLLS)
  ) u_budget (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .bump  (rd_take),
    .spent (spent)
  );

  assign rd_addr = poll_addr;
  assign wr_addr = poll_addr;
  assign wr_data = RST_CMD;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_req  <= 1'b0;
      wr_req  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            busy    <= 1'b1;
            rd_req  <= 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ack) begin
            rd_req  <= 1'b0;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (verdict == VD_MATCH) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else if (spent) begin
            wr_req  <= 1'b1;
            state_q <= ST_RSTWR;
          end else if (verdict == VD_TOUT) begin
            rd_req  <= 1'b1;
            state_q <= ST_RCHK;
          end else begin
            rd_req  <= 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_RCHK: begin
          if (rd_ack) begin
            rd_req  <= 1'b0;
            state_q <= ST_RCHK_E;
          end
        end
        ST_RCHK_E: begin
          if (verdict == VD_MATCH) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            wr_req  <= 1'b1;
            state_q <= ST_RSTWR;
          end
        end
        ST_RSTWR: begin
          if (wr_ack) begin
            wr_req  <= 1'b0;
            fail    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          rd_req  <= 1'b0;
          wr_req  <= 1'b0;
          busy    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fp_poller_chk.sv
module fp_poller_chk #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int ALIGN_BITS = 2,
  parameter int MAX_POLLS  = 4096,
  parameter logic [DATA_W-1:0] RST_CMD = DATA_W'('hF0)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              wr_req,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ack,
  input logic              busy,
  input logic              done,
  input logic              fail
);
  localparam int CW = $clog2(MAX_POLLS + 2);

  logic [CW-1:0] reads_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      reads_seen <= '0;
    end else if (start && !busy) begin
      reads_seen <= '0;
    end else if (rd_req && rd_ack && reads_seen != CW'(MAX_POLLS + 1)) begin
      reads_seen <= reads_seen + CW'(1);
    end
  end

  // R3
  rd_addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[ALIGN_BITS-1:0] == '0);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && rd_req));

  // R8
  read_budget_chk: assert property (@(posedge clk) disable iff (rst)
    reads_seen <= CW'(MAX_POLLS));

  // R9
  wr_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> wr_data == RST_CMD);

  // R9
  fail_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(wr_req && wr_ack));

  // R10
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  // R10
  result_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (!busy && $past(busy)));

  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req) |-> busy);
endmodule

bind flash_done_poller fp_poller_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .ALIGN_BITS (ALIGN_BITS),
  .MAX_POLLS  (MAX_POLLS),
  .RST_CMD    (RST_CMD)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .rd_req  (rd_req),
  .rd_addr (rd_addr),
  .rd_ack  (rd_ack),
  .wr_req  (wr_req),
  .wr_data (wr_data),
  .wr_ack  (wr_ack),
  .busy    (busy),
  .done    (done),
  .fail    (fail)
);

// File: tb/sim_flash_done_poller.sv
`timescale 1ns/1ps
module sim_flash_done_poller;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MAXP = 6;
  localparam logic [DW-1:0] CMD = 8'hF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic op_erase = 1'b0;
  logic [AW-1:0] target_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic wr_req;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic wr_ack = 1'b0;
  logic busy, done, fail;

  always #2.5 clk = ~clk;

  flash_done_poller #(
    .ADDR_W (AW), .DATA_W (DW), .MAX_POLLS (MAXP), .RST_CMD (CMD)
  ) u0 (
    .clk (clk), .rst (rst), .start (start), .op_erase (op_erase),
    .target_addr (target_addr), .wdata (wdata),
    .rd_req (rd_req), .rd_addr (rd_addr), .rd_ack (rd_ack), .rd_data (rd_data),
    .wr_req (wr_req), .wr_addr (wr_addr), .wr_data (wr_data), .wr_ack (wr_ack),
    .busy (busy), .done (done), .fail (fail)
  );

  int n_chk = 0;
  int n_bad = 0;

  // scenario shared with the responder (written by main only)
  logic       sc_exp7 = 1'b0;
  int         sc_fin = 1;
  int         sc_d5 = 1;
  int         base_reads = 0;
  logic [AW-1:0] sc_addr = '0;

  // responder state (written by responder only)
  int rcount = 0;
  int wcount = 0;
  int addr_err = 0;
  logic [DW-1:0] last_wdata = '0;
  logic [AW-1:0] last_waddr = '0;

  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      int idx;
      idx = rcount - base_reads + 1;
      rd_ack  <= 1'b1;
      rd_data <= {(idx >= sc_fin) ? sc_exp7 : ~sc_exp7, 1'b1,
                  (idx >= sc_d5) ? 1'b1 : 1'b0, 5'(idx * 3)};
      if (rd_addr != sc_addr) addr_err <= addr_err + 1;
      rcount <= rcount + 1;
    end else begin
      rd_ack <= 1'b0;
    end
    if (wr_req && !wr_ack) begin
      wr_ack     <= 1'b1;
      wcount     <= wcount + 1;
      last_wdata <= wr_data;
      last_waddr <= wr_addr;
    end else begin
      wr_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input bit er, input bit wb7, input int fin, input int d5, input int k);
    int r0, w0, a0, reads, pulses, dn, fl, cyc;
    bit exp_pass;
    int exp_reads;
    logic [AW-1:0] a;
    // expected outcome from the requirements
    exp_reads = 0;
    exp_pass = 1'b0;
    forever begin
      exp_reads++;
      if (exp_reads >= fin) begin exp_pass = 1'b1; break; end
      if (exp_reads == MAXP) break;
      if (exp_reads >= d5) begin
        exp_reads++;
        exp_pass = (exp_reads >= fin);
        break;
      end
    end
    a = AW'(k * 37 + 3);
    @(negedge clk);
    r0 = rcount; w0 = wcount; a0 = addr_err;
    base_reads = rcount;
    sc_exp7 = er ? 1'b1 : wb7;
    sc_fin = fin; sc_d5 = d5;
    sc_addr = a & 8'hFC;
    op_erase = er; target_addr = a; wdata = {wb7, 7'h2A};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && rd_req, "R2 busy/rd_req after start", busy, 1);
    @(negedge clk);
    // second start while busy must be ignored (R2)
    start = 1'b1; op_erase = ~er; target_addr = a ^ 8'hF0; wdata = {~wb7, 7'h55};
    pulses = 0; dn = 0; fl = 0; cyc = 0;
    if (done || fail) begin pulses++; dn += int'(done); fl += int'(fail); end
    @(negedge clk);
    start = 1'b0;
    while (cyc < 200) begin
      if (done || fail) begin
        pulses++; dn += int'(done); fl += int'(fail);
        check(!busy, "R10 busy low with result", busy, 0);
      end
      if (pulses > 0 && !busy && !rd_req && !wr_req) break;
      @(negedge clk);
      cyc++;
    end
    check(cyc < 200, "R10 result within window", cyc, 0);
    repeat (3) begin
      @(negedge clk);
      if (done || fail) pulses++;
    end
    reads = rcount - r0;
    check(pulses == 1, "R10 one result pulse", pulses, 1);
    if (er) check(dn == int'(exp_pass), "R5 erase outcome", dn, int'(exp_pass));
    else    check(dn == int'(exp_pass), "R4 program outcome", dn, int'(exp_pass));
    check(reads == exp_reads, (d5 < fin) ? "R6 read count" : "R7 read count", reads, exp_reads);
    check(reads <= MAXP, "R8 read budget", reads, MAXP);
    check(addr_err - a0 == 0, "R3 poll address", addr_err - a0, 0);
    check(wcount - w0 == (exp_pass ? 0 : 1), "R9 reset write count",
          wcount - w0, exp_pass ? 0 : 1);
    if (!exp_pass) begin
      check(last_wdata == CMD, "R9 reset command", last_wdata, CMD);
      check(last_waddr == (a & 8'hFC), "R9 reset address", last_waddr, a & 8'hFC);
      check(fl == 1, "R9 fail pulse", fl, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !fail && !rd_req && !wr_req, "R1 reset state",
          {busy, done, fail, rd_req, wr_req}, 0);
    for (int er = 0; er < 2; er++)
      for (int wb = 0; wb < 2; wb++)
        for (int fin = 1; fin <= MAXP + 2; fin++)
          for (int d5 = 1; d5 <= MAXP + 2; d5++)
            run(er[0], wb[0], fin, d5, er * 64 + wb * 32 + fin * 9 + d5);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(150000 * 5);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end
endmodule